// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block is the control side of a byte-wide parallel NOR flash device, built as synthesizable logic around a small on-chip byte array. It takes the device pins (active-low chip enable, output enable, write enable and hardware reset), a 22-bit address and an 8-bit data input. All pins are sampled synchronously to a system clock. The block drives an 8-bit data output together with an output-enable that stands for the tri-state control of the shared data bus.

Bus writes are collected into a command register. A command state machine walks through multi-write unlock sequences. A finished sequence switches reads to identification codes, programs a byte, or erases a sector or the whole array. A write with a wrong address, wrong data or out of order drops the machine straight back to plain array reads. Programming and erase need no status polling. A program lands two clocks after its data write. An erase sweeps the array at one byte per clock.

The implemented array fills the lowest 2^ARR_AW bytes of the address space, and each sector holds 2^SECT_AW bytes. With the defaults that is 1024 bytes in four sectors, and the sector number is address bits 9:8. The array powers up with every byte at 0xFF.

Top module: `nor_flash_ctl`

## Requirements
- R1: A read cycle happens only while ce_n=0, oe_n=0, we_n=1 and hw_rst_n=1. Three clocks after the pins settle, dq_en is 1 and dq_o holds the byte selected by the current read mode for the applied address.
- R2: dq_en is 0 three clocks after any sample with ce_n=1, oe_n=1 or hw_rst_n=0, whatever the other pins are.
- R3: A bus write is taken when we_n rises after a low phase in which ce_n was 0 and oe_n was 1. The address and data captured are those present while we_n was low. A low pulse of we_n while oe_n is 0 is ignored.
- R4: After rst, and after hw_rst_n is held low, the machine is in array-read mode. Array bytes can then be read with no command.
- R5: Only address bits 10:0 are compared during unlock. The sequence 0xAA to 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555 enters identification mode. Reads then return a code chosen by address bits 1:0: 0 gives 0x01, 1 gives 0x41, and 2 or 3 give 0x00.
- R6: Any write in identification mode returns the machine to array-read mode. The usual exit is 0xF0.
- R7: A write whose address or data does not match the next step of a sequence, including a valid step given out of order, returns the machine to array-read mode and changes nothing in the array.
- R8: The unlock pair, then 0xA0 to 0x555, then one address/data write programs that byte. The new content is the old byte ANDed with the written data.
- R9: The unlock pair, 0x80 to 0x555, the unlock pair again, then 0x30 to any address inside a sector sets every byte of that sector to 0xFF and leaves the other sectors unchanged. Several sectors are erased by repeating the sequence.
- R10: The same erase prefix followed by 0x10 to 0x555 sets every byte of the array to 0xFF.
- R11: While an erase sweep is running, every bus write is ignored.
- R12: Addresses with any bit above the implemented array set read as 0xFF in array-read mode. Programs and sector erases aimed at them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the logic |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| hw_rst_n | input | 1 | Device hardware reset pin, active low |
| addr | input | 22 | Byte address |
| dq_i | input | 8 | Data bus value driven by the host during writes |
| dq_o | output | 8 | Data the block places on the bus during reads |
| dq_en | output | 1 | High when the block drives the data bus; low means high impedance |

## Verification
The hardest state to reach from the pins is a write that arrives while an erase sweep is still running. Only a complete six-write erase sequence starts a sweep, and the sweep lasts only as many clocks as the sector has bytes. The bench therefore issues a full program sequence directly after the erase command, well inside the sweep window. It then reads back both the erased sector and the program target. The aborted-sequence cases are reached in a similar way: a near-correct prefix is sent, then a would-be program write, and the bench checks that the target byte kept its earlier programmed value.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  localparam int UNLK_AW = 11;

  localparam logic [UNLK_AW-1:0] ADR_A = 11'h555;
  localparam logic [UNLK_AW-1:0] ADR_B = 11'h2AA;

  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_CHIP    = 8'h10;

  typedef enum logic [2:0] {
    ST_ARRAY,
    ST_KEY1,
    ST_KEY2,
    ST_IDENT,
    ST_PROG,
    ST_EKEY0,
    ST_EKEY1,
    ST_EKEY2
  } cmd_state_t;

endpackage

// File: rtl/nor_pin_sync.sv
module nor_pin_sync #(
  parameter int AW      = 22,
  parameter int DW      = 8,
  parameter int ARR_AW  = 10,
  parameter int UW      = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hw_rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic              rd_en,
  output logic              dev_rst,
  output logic [ARR_AW-1:0] rd_addr,
  output logic              rd_hi,
  output logic              wr_stb,
  output logic [UW-1:0]     cmd_addr,
  output logic              cmd_hi,
  output logic [DW-1:0]     cmd_data
);

  logic p_ce, p_oe, p_we, p_rst;
  logic ce_q, oe_q, we_q;
  logic wr_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_ce    <= 1'b1;
      p_oe    <= 1'b1;
      p_we    <= 1'b1;
      p_rst   <= 1'b1;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      rd_addr <= '0;
      rd_hi   <= 1'b0;
    end else begin
      p_ce    <= ce_n;
      p_oe    <= oe_n;
      p_we    <= we_n;
      p_rst   <= hw_rst_n;
      ce_q    <= p_ce;
      oe_q    <= p_oe;
      we_q    <= p_we;
      rd_addr <= addr[ARR_AW-1:0];
      rd_hi   <= |addr[AW-1:ARR_AW];
    end
  end

  assign wr_phase = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_addr <= '0;
      cmd_hi   <= 1'b0;
      cmd_data <= '0;
    end else if (wr_phase) begin
      cmd_addr <= addr[UW-1:0];
      cmd_hi   <= |addr[AW-1:ARR_AW];
      cmd_data <= din;
    end
  end

  assign rd_en   = !p_ce && !p_oe && p_we && p_rst;
  assign dev_rst = !p_rst;
  assign wr_stb  = p_we && !we_q && !ce_q && oe_q && p_rst;

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_flash_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ARR_AW  = 10,
  parameter int SECT_AW = 8,
  parameter int UW      = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dev_rst,
  input  logic                      busy,
  input  logic                      wr_stb,
  input  logic [UW-1:0]             cmd_addr,
  input  logic                      cmd_hi,
  input  logic [DW-1:0]             cmd_data,
  output logic                      autosel,
  output logic                      pgm_req,
  output logic [ARR_AW-1:0]         pgm_addr,
  output logic [DW-1:0]             pgm_data,
  output logic                      ers_req,
  output logic                      ers_chip,
  output logic [ARR_AW-SECT_AW-1:0] ers_sect
);

  cmd_state_t state;
  logic at_a, at_b;

  assign at_a = (cmd_addr == ADR_A);
  assign at_b = (cmd_addr == ADR_B);

  always_ff @(posedge clk) begin
    if (rst || dev_rst) begin
      state    <= ST_ARRAY;
      pgm_req  <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
      ers_req  <= 1'b0;
      ers_chip <= 1'b0;
      ers_sect <= '0;
    end else begin
      pgm_req <= 1'b0;
      ers_req <= 1'b0;
      if (wr_stb && !busy) begin
        state <= ST_ARRAY;
        case (state)
          ST_ARRAY: if (at_a && cmd_data == KEY_A) state <= ST_KEY1;
          ST_KEY1:  if (at_b && cmd_data == KEY_B) state <= ST_KEY2;
          ST_KEY2: begin
            if (at_a && cmd_data == OP_IDENT) state <= ST_IDENT;
            if (at_a && cmd_data == OP_PROG)  state <= ST_PROG;
            if (at_a && cmd_data == OP_ERASE) state <= ST_EKEY0;
          end
          ST_PROG: begin
            pgm_req  <= !cmd_hi;
            pgm_addr <= cmd_addr[ARR_AW-1:0];
            pgm_data <= cmd_data;
          end
          ST_EKEY0: if (at_a && cmd_data == KEY_A) state <= ST_EKEY1;
          ST_EKEY1: if (at_b && cmd_data == KEY_B) state <= ST_EKEY2;
          ST_EKEY2: begin
            ers_sect <= cmd_addr[ARR_AW-1:SECT_AW];
            if (cmd_data == OP_SECTOR && !cmd_hi) begin
              ers_req  <= 1'b1;
              ers_chip <= 1'b0;
            end else if (at_a && cmd_data == OP_CHIP) begin
              ers_req  <= 1'b1;
              ers_chip <= 1'b1;
            end
          end
          default: state <= ST_ARRAY;
        endcase
      end
    end
  end

  assign autosel = (state == ST_IDENT);

endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int DW      = 8,
  parameter int ARR_AW  = 10,
  parameter int SECT_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dev_rst,
  input  logic [ARR_AW-1:0]         rd_addr,
  output logic [DW-1:0]             rd_data,
  input  logic                      pgm_req,
  input  logic [ARR_AW-1:0]         pgm_addr,
  input  logic [DW-1:0]             pgm_data,
  input  logic                      ers_req,
  input  logic                      ers_chip,
  input  logic [ARR_AW-SECT_AW-1:0] ers_sect,
  output logic                      busy
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [DW-1:0]     mem [DEPTH];
  logic [ARR_AW-1:0] ra;
  logic              pg_v;
  logic [ARR_AW-1:0] pg_a;
  logic [DW-1:0]     pg_d;
  logic [ARR_AW-1:0] ptr, last;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // program reads the old byte first, then writes the AND
  assign ra = pgm_req ? pgm_addr : rd_addr;

  always_ff @(posedge clk) begin
    rd_data <= mem[ra];
    if (busy)      mem[ptr]  <= '1;
    else if (pg_v) mem[pg_a] <= rd_data & pg_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_v <= 1'b0;
      pg_a <= '0;
      pg_d <= '0;
    end else begin
      pg_v <= pgm_req;
      pg_a <= pgm_addr;
      pg_d <= pgm_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || dev_rst) begin
      busy <= 1'b0;
      ptr  <= '0;
      last <= '0;
    end else if (ers_req) begin
      busy <= 1'b1;
      ptr  <= ers_chip ? '0 : {ers_sect, {SECT_AW{1'b0}}};
      last <= ers_chip ? '1 : {ers_sect, {SECT_AW{1'b1}}};
    end else if (busy) begin
      if (ptr == last) busy <= 1'b0;
      else             ptr  <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/nor_flash_ctl.sv
module nor_flash_ctl
  import nor_flash_pkg::*;
#(
  parameter int          AW       = 22,
  parameter int          DW       = 8,
  parameter int          ARR_AW   = 10,
  parameter int          SECT_AW  = 8,
  parameter logic [7:0]  MFR_CODE = 8'h01,
  parameter logic [7:0]  DEV_CODE = 8'h41
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hw_rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_en
);

  localparam int SW = ARR_AW - SECT_AW;

  logic              rd_en, dev_rst, rd_hi, wr_stb, cmd_hi;
  logic [ARR_AW-1:0] rd_addr;
  logic [UNLK_AW-1:0] cmd_addr;
  logic [DW-1:0]     cmd_data;
  logic              autosel, pgm_req, ers_req, ers_chip, er_busy;
  logic [ARR_AW-1:0] pgm_addr;
  logic [DW-1:0]     pgm_data, arr_q;
  logic [SW-1:0]     ers_sect;

  nor_pin_sync #(.AW(AW), .DW(DW), .ARR_AW(ARR_AW), .UW(UNLK_AW)) u_sync (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .addr(addr), .din(dq_i),
    .rd_en(rd_en), .dev_rst(dev_rst), .rd_addr(rd_addr), .rd_hi(rd_hi),
    .wr_stb(wr_stb), .cmd_addr(cmd_addr), .cmd_hi(cmd_hi), .cmd_data(cmd_data)
  );

  nor_cmd_fsm #(.DW(DW), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW), .UW(UNLK_AW)) u_fsm (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .busy(er_busy),
    .wr_stb(wr_stb), .cmd_addr(cmd_addr), .cmd_hi(cmd_hi), .cmd_data(cmd_data),
    .autosel(autosel), .pgm_req(pgm_req), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .ers_req(ers_req), .ers_chip(ers_chip),
    .ers_sect(ers_sect)
  );

  nor_array #(.DW(DW), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_arr (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .rd_addr(rd_addr),
    .rd_data(arr_q), .pgm_req(pgm_req), .pgm_addr(pgm_addr),
    .pgm_data(pgm_data), .ers_req(ers_req), .ers_chip(ers_chip),
    .ers_sect(ers_sect), .busy(er_busy)
  );

  logic          en_s1, asel_s1, hi_s1;
  logic [DW-1:0] id_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_s1   <= 1'b0;
      asel_s1 <= 1'b0;
      hi_s1   <= 1'b0;
      id_s1   <= '0;
      dq_en   <= 1'b0;
      dq_o    <= '0;
    end else begin
      en_s1   <= rd_en;
      asel_s1 <= autosel;
      hi_s1   <= rd_hi;
      case (rd_addr[1:0])
        2'd0:    id_s1 <= DW'(MFR_CODE);
        2'd1:    id_s1 <= DW'(DEV_CODE);
        default: id_s1 <= '0;
      endcase
      dq_en <= en_s1;
      if (asel_s1)    dq_o <= id_s1;
      else if (hi_s1) dq_o <= '1;
      else            dq_o <= arr_q;
    end
  end

endmodule

// File: rtl/nor_flash_ctl_chk.sv
module nor_flash_ctl_chk (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic hw_rst_n,
  input logic dq_en,
  input logic wr_stb,
  input logic autosel,
  input logic er_busy,
  input logic pgm_req
);

  // R1
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dq_en |-> ($past(!ce_n, 3) && $past(!oe_n, 3) && $past(we_n, 3) && $past(hw_rst_n, 3)));

  // R2
  bus_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_n, 3) || $past(oe_n, 3) || !$past(hw_rst_n, 3)) |-> !dq_en);

  // R3
  wr_take_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ($past(!ce_n, 2) && $past(oe_n, 2)));

  // R4
  hw_rst_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!hw_rst_n, 2) |-> (!autosel && !er_busy));

  // R5
  ident_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(autosel) |-> $past(wr_stb));

  // R11
  erase_lock_chk: assert property (@(posedge clk) disable iff (rst)
    er_busy |-> !pgm_req);

endmodule

bind nor_flash_ctl nor_flash_ctl_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .hw_rst_n(hw_rst_n), .dq_en(dq_en), .wr_stb(wr_stb), .autosel(autosel),
  .er_busy(er_busy), .pgm_req(pgm_req)
);

// File: tb/test_nor_flash_ctl.sv
`timescale 1ns/1ps
module test_nor_flash_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_rst_n = 1'b1;
  logic [21:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_en;

  always #2 clk = ~clk;

  nor_flash_ctl i_nor_flash_ctl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
  );

  typedef struct {
    logic       en;
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  event smp_ev;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // monitor: pops one expected item per sample point
  initial begin
    forever begin
      @(smp_ev);
      if (sb_q.size() != 0) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (dq_en !== it.en || (it.en && dq_o !== it.d)) begin
          fails++;
          $display("FAIL %s: got en=%b dq=%h, expected en=%b dq=%h",
                   it.tag, dq_en, dq_o, it.en, it.d);
        end
      end
    end
  end

  task automatic idle(input int n);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hw_rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic probe(input logic c, input logic o, input logic w, input logic r,
                       input logic [21:0] a, input logic e, input logic [7:0] d,
                       input string tag);
    exp_t it;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; hw_rst_n = r; addr = a;
    repeat (4) @(negedge clk);
    it.en = e; it.d = d; it.tag = tag;
    sb_q.push_back(it);
    -> smp_ev;
    #1;
    idle(1);
  endtask

  task automatic rd(input logic [21:0] a, input logic [7:0] d, input string tag);
    probe(1'b0, 1'b0, 1'b1, 1'b1, a, 1'b1, d, tag);
  endtask

  task automatic wr(input logic [21:0] a, input logic [7:0] d, input logic oe);
    @(negedge clk);
    addr = a; dq_i = d; ce_n = 1'b0; oe_n = oe; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(22'h555, 8'hAA, 1'b1);
    wr(22'h2AA, 8'h55, 1'b1);
  endtask

  task automatic prog(input logic [21:0] a, input logic [7:0] d);
    unlock();
    wr(22'h555, 8'hA0, 1'b1);
    wr(a, d, 1'b1);
    idle(3);
  endtask

  task automatic erase_pre();
    unlock();
    wr(22'h555, 8'h80, 1'b1);
    unlock();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(4);

    // R2 reset state: nothing driven
    probe(1'b1, 1'b1, 1'b1, 1'b1, 22'h0, 1'b0, 8'h00, "R2 reset idle");
    // R4 R1 blank array readable with no command
    rd(22'h005, 8'hFF, "R4 R1 blank read");

    // R8 program then AND on reprogram
    prog(22'h005, 8'h3C);
    rd(22'h005, 8'h3C, "R8 first program");
    prog(22'h005, 8'hF5);
    rd(22'h005, 8'h34, "R8 AND with old byte");

    // R5 identification mode
    unlock();
    wr(22'h555, 8'h90, 1'b1);
    rd(22'h000, 8'h01, "R5 code at offset 0");
    rd(22'h001, 8'h41, "R5 code at offset 1");
    rd(22'h002, 8'h00, "R5 code at offset 2");
    // R6 exit
    wr(22'h123, 8'hF0, 1'b1);
    rd(22'h000, 8'hFF, "R6 back to array at 0");
    rd(22'h005, 8'h34, "R6 back to array at 5");

    // R7 wrong data in the second unlock write
    wr(22'h555, 8'hAA, 1'b1);
    wr(22'h2AA, 8'h56, 1'b1);
    wr(22'h555, 8'hA0, 1'b1);
    wr(22'h005, 8'h00, 1'b1);
    rd(22'h005, 8'h34, "R7 bad key, no program");
    // R7 out of order
    wr(22'h2AA, 8'h55, 1'b1);
    wr(22'h555, 8'hAA, 1'b1);
    wr(22'h555, 8'h90, 1'b1);
    rd(22'h000, 8'hFF, "R7 out of order, no ident");

    // R2 and R1 bus off cases
    probe(1'b0, 1'b1, 1'b1, 1'b1, 22'h005, 1'b0, 8'h00, "R2 output disabled");
    probe(1'b1, 1'b0, 1'b1, 1'b1, 22'h005, 1'b0, 8'h00, "R2 standby");
    probe(1'b0, 1'b0, 1'b1, 1'b0, 22'h005, 1'b0, 8'h00, "R2 hardware reset");
    probe(1'b0, 1'b0, 1'b0, 1'b1, 22'h005, 1'b0, 8'h00, "R1 we low blocks read");

    // R3 write with oe low ignored; next valid write programs
    unlock();
    wr(22'h555, 8'hA0, 1'b1);
    wr(22'h005, 8'h00, 1'b0);
    wr(22'h005, 8'h1F, 1'b1);
    idle(3);
    rd(22'h005, 8'h14, "R3 oe-low write ignored");

    // R4 hardware reset leaves identification mode
    unlock();
    wr(22'h555, 8'h90, 1'b1);
    @(negedge clk);
    hw_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    hw_rst_n = 1'b1;
    idle(2);
    rd(22'h001, 8'hFF, "R4 hw reset to array mode");

    // R9 sector erase
    prog(22'h105, 8'h00);
    prog(22'h205, 8'h12);
    prog(22'h3FF, 8'hA5);
    rd(22'h105, 8'h00, "R8 sector 1 programmed");
    erase_pre();
    wr(22'h1AB, 8'h30, 1'b1);
    idle(300);
    rd(22'h105, 8'hFF, "R9 sector 1 erased");
    rd(22'h205, 8'h12, "R9 sector 2 kept");
    rd(22'h005, 8'h14, "R9 sector 0 kept");

    // R11 program issued during a sweep
    erase_pre();
    wr(22'h2C0, 8'h30, 1'b1);
    prog(22'h005, 8'h00);
    idle(300);
    rd(22'h005, 8'h14, "R11 write during erase ignored");
    rd(22'h205, 8'hFF, "R9 second sector erased");

    // R12 addresses above the array
    rd(22'h200005, 8'hFF, "R12 high address reads FF");
    prog(22'h200005, 8'h00);
    rd(22'h005, 8'h14, "R12 high program ignored");

    // R10 chip erase
    erase_pre();
    wr(22'h555, 8'h10, 1'b1);
    idle(1100);
    rd(22'h005, 8'hFF, "R10 chip erase low byte");
    rd(22'h3FF, 8'hFF, "R10 chip erase top byte");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule